// File: doc/BRIEF.md
# Rotating priority interrupt resolver

This block is the decision core of an eight-line interrupt controller. Each input line feeds a request bit. Software picks, line by line, whether a bit follows the input level or latches on a rising edge. A mask register holds back chosen requests. An in-service register records the interrupts the processor is handling. Priority starts from a programmable base position and wraps round the lines. The block raises its interrupt output only when the best unmasked request strictly outranks everything in service.

The processor acknowledges the offered interrupt with a one-cycle strobe. It retires interrupts with end-of-interrupt strobes. One form retires the best in-service line and the other retires a named line. Either form can move the priority base to sit just after the retired line. An automatic end-of-interrupt mode retires a line at acknowledge time and can rotate the base as well. A nested option, used on the master instance, stops the in-service bit of the cascade line from blocking further requests.

The interrupt output and the vector index are combinational functions of the registers. A registered copy of the output is also provided.

Top module: `prio_irq_core`

## Requirements
- R1: A synchronous reset clears the request, in-service, mask, trigger-mode, priority base and mode registers and the edge history. It also clears `int_req_q`, so `int_out` is low after reset.
- R2: On a line in edge mode (trigger bit 0), the request bit sets on a rising input edge that is detected against the stored previous level. A falling input clears only the stored level and leaves the request bit set.
- R3: On a line in level mode (trigger bit 1), the request bit follows the input one clock later, both when the input rises and when it falls.
- R4: A trigger-mode write stores `trig_wd & TRIG_WMASK`. Bits outside `TRIG_WMASK` always read 0, and their lines stay in edge mode.
- R5: The winner is the candidate line found first when positions (n + base) mod 8 are scanned for n = 0, 1, …, 7. `int_vec` gives that line, and a base write takes effect from the next cycle.
- R6: The candidate set is request AND NOT mask. `int_out` is high only when the winner's scan rank is strictly smaller than the best scan rank in the in-service register. An empty candidate set gives no interrupt.
- R7: An acknowledge while `int_out` is high sets the in-service bit of `int_vec`. It clears the request bit only for an edge-mode line. An acknowledge while `int_out` is low changes nothing.
- R8: With automatic end of interrupt set, an acknowledge leaves the in-service bit clear. If rotate-on-automatic-EOI is also set, the base becomes (vector + 1) mod 8.
- R9: A non-specific EOI clears the in-service bit with the best scan rank. With `eoi_rot` set, the base becomes (that line + 1) mod 8.
- R10: A specific EOI clears in-service bit `eoi_id`. With `eoi_rot` set, the base becomes (`eoi_id` + 1) mod 8. It takes precedence over a non-specific EOI in the same cycle.
- R11: In a master instance with the nested option set, in-service bit `CASC_LINE` (default 2) is ignored when the in-service rank is computed.
- R12: `int_req_q` equals `int_out` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | N | Interrupt input lines |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wd | input | N | Mask data, 1 = line masked |
| trig_we | input | 1 | Write strobe for the trigger-mode register |
| trig_wd | input | N | Trigger data, 1 = level mode |
| base_we | input | 1 | Write strobe for the priority base |
| base_wd | input | log2 N | New priority base |
| mode_we | input | 1 | Write strobe for the mode bits |
| mode_aeoi | input | 1 | Automatic end-of-interrupt enable |
| mode_rot_aeoi | input | 1 | Rotate on automatic EOI |
| mode_nested | input | 1 | Nested option for the cascade line |
| ack | input | 1 | Acknowledge strobe |
| eoi_any | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_one | input | 1 | Specific end-of-interrupt strobe |
| eoi_id | input | log2 N | Line retired by a specific EOI |
| eoi_rot | input | 1 | Rotate the base on this EOI |
| int_out | output | 1 | Combinational interrupt request |
| int_vec | output | log2 N | Line being offered |
| int_req_q | output | 1 | Registered copy of int_out |
| irr_o | output | N | Request register |
| isr_o | output | N | In-service register |
| imr_o | output | N | Mask register |
| trig_o | output | N | Trigger-mode register |
| base_o | output | log2 N | Priority base |

## Verification
The bench builds the block with its default parameters: a master instance with a trigger write mask of 0xF8 and the cascade line at 2. The 0xF8 mask leaves lines 0 to 2 fixed in edge mode while line 4 can be switched to level mode, so R4 is exercised in both directions. The master setting makes the nested option take effect on line 2, so R11 shows up as a change in `int_out`. Base values of 0, 4 and 6 move the wrap point between the two competing lines, which makes R5 observable.

// File: rtl/prio_irq_core.sv
module prio_irq_core #(
  parameter int N = 8,
  parameter logic [N-1:0] TRIG_WMASK = 8'hF8,
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         irq_in,
  input  logic                 mask_we,
  input  logic [N-1:0]         mask_wd,
  input  logic                 trig_we,
  input  logic [N-1:0]         trig_wd,
  input  logic                 base_we,
  input  logic [$clog2(N)-1:0] base_wd,
  input  logic                 mode_we,
  input  logic                 mode_aeoi,
  input  logic                 mode_rot_aeoi,
  input  logic                 mode_nested,
  input  logic                 ack,
  input  logic                 eoi_any,
  input  logic                 eoi_one,
  input  logic [$clog2(N)-1:0] eoi_id,
  input  logic                 eoi_rot,
  output logic                 int_out,
  output logic [$clog2(N)-1:0] int_vec,
  output logic                 int_req_q,
  output logic [N-1:0]         irr_o,
  output logic [N-1:0]         isr_o,
  output logic [N-1:0]         imr_o,
  output logic [N-1:0]         trig_o,
  output logic [$clog2(N)-1:0] base_o
);
  localparam int IW = $clog2(N);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASC_LINE;

  logic [N-1:0]  irr, isr, imr, trig, last;
  logic [N-1:0]  irr_n, isr_n;
  logic [IW-1:0] base, base_n;
  logic          aeoi, rot_aeoi, nested;

  // Rank of the first set bit when scanning from position base; N if empty.
  function automatic logic [IW:0] rank(input logic [N-1:0] s, input logic [IW-1:0] b);
    logic [2*N-1:0] dbl;
    logic [IW:0]    p;
    dbl = {s, s} >> b;
    p = (IW+1)'(N);
    for (int i = N-1; i >= 0; i--)
      if (dbl[i]) p = (IW+1)'(i);
    return p;
  endfunction

  logic [N-1:0]  cand, isr_view;
  logic [IW:0]   cand_p, cur_p, isr_p;
  logic [IW-1:0] isr_top;
  logic          isr_hit, ack_go;

  assign cand     = irr & ~imr;
  assign isr_view = (IS_MASTER && nested) ? (isr & ~CASC_BIT) : isr;
  assign cand_p   = rank(cand, base);
  assign cur_p    = rank(isr_view, base);
  assign isr_p    = rank(isr, base);
  assign int_out  = cand_p < cur_p;
  assign int_vec  = cand_p[IW-1:0] + base;
  assign isr_hit  = isr_p != (IW+1)'(N);
  assign isr_top  = isr_p[IW-1:0] + base;
  assign ack_go   = ack && int_out;

  always_comb begin
    irr_n = irr;
    for (int i = 0; i < N; i++) begin
      if (trig[i])
        irr_n[i] = irq_in[i];
      else if (irq_in[i] && !last[i])
        irr_n[i] = 1'b1;
    end
    if (ack_go && !trig[int_vec])
      irr_n[int_vec] = 1'b0;

    isr_n = isr;
    if (ack_go && !aeoi)
      isr_n[int_vec] = 1'b1;
    if (eoi_one)
      isr_n[eoi_id] = 1'b0;
    else if (eoi_any && isr_hit)
      isr_n[isr_top] = 1'b0;

    base_n = base;
    if (base_we)
      base_n = base_wd;
    if (ack_go && aeoi && rot_aeoi)
      base_n = int_vec + IW'(1);
    if (eoi_one && eoi_rot)
      base_n = eoi_id + IW'(1);
    else if (eoi_any && eoi_rot && isr_hit)
      base_n = isr_top + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr       <= '0;
      isr       <= '0;
      imr       <= '0;
      trig      <= '0;
      last      <= '0;
      base      <= '0;
      aeoi      <= 1'b0;
      rot_aeoi  <= 1'b0;
      nested    <= 1'b0;
      int_req_q <= 1'b0;
    end else begin
      irr       <= irr_n;
      isr       <= isr_n;
      last      <= irq_in;
      base      <= base_n;
      int_req_q <= int_out;
      if (mask_we) imr  <= mask_wd;
      if (trig_we) trig <= trig_wd & TRIG_WMASK;
      if (mode_we) begin
        aeoi     <= mode_aeoi;
        rot_aeoi <= mode_rot_aeoi;
        nested   <= mode_nested;
      end
    end
  end

  assign irr_o  = irr;
  assign isr_o  = isr;
  assign imr_o  = imr;
  assign trig_o = trig;
  assign base_o = base;
endmodule

module prio_irq_core_chk #(
  parameter int N = 8,
  parameter logic [N-1:0] TRIG_WMASK = 8'hF8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ack,
  input logic                 eoi_any,
  input logic                 eoi_one,
  input logic                 int_out,
  input logic [$clog2(N)-1:0] int_vec,
  input logic                 int_req_q,
  input logic [N-1:0]         irr_o,
  input logic [N-1:0]         isr_o,
  input logic [N-1:0]         imr_o,
  input logic [N-1:0]         trig_o,
  input logic [$clog2(N)-1:0] base_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (irr_o == '0 && isr_o == '0 && imr_o == '0 && trig_o == '0 &&
             base_o == '0 && int_req_q == 1'b0));

  assert_trig_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (trig_o & ~TRIG_WMASK) == '0);

  assert_cand_valid_R6: assert property (@(posedge clk) disable iff (rst)
    int_out |-> (irr_o[int_vec] && !imr_o[int_vec]));

  assert_isr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!ack && !eoi_any && !eoi_one) |=> $stable(isr_o));

  assert_edge_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (ack && int_out && !trig_o[int_vec]) |=> !irr_o[$past(int_vec)]);

  assert_req_delay_R12: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (int_req_q == $past(int_out)));
endmodule

bind prio_irq_core prio_irq_core_chk #(.N(N), .TRIG_WMASK(TRIG_WMASK)) u_chk (.*);

// File: tb/test_prio_irq_core.sv
module test_prio_irq_core;
  logic clk = 1'b0;
  logic rst;
  logic [7:0] irq_in, mask_wd, trig_wd;
  logic mask_we, trig_we, base_we, mode_we;
  logic [2:0] base_wd, eoi_id;
  logic mode_aeoi, mode_rot_aeoi, mode_nested;
  logic ack, eoi_any, eoi_one, eoi_rot;
  logic int_out, int_req_q;
  logic [2:0] int_vec, base_o;
  logic [7:0] irr_o, isr_o, imr_o, trig_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_core i_prio_irq_core (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .mask_we(mask_we), .mask_wd(mask_wd),
    .trig_we(trig_we), .trig_wd(trig_wd),
    .base_we(base_we), .base_wd(base_wd),
    .mode_we(mode_we), .mode_aeoi(mode_aeoi), .mode_rot_aeoi(mode_rot_aeoi),
    .mode_nested(mode_nested),
    .ack(ack), .eoi_any(eoi_any), .eoi_one(eoi_one), .eoi_id(eoi_id), .eoi_rot(eoi_rot),
    .int_out(int_out), .int_vec(int_vec), .int_req_q(int_req_q),
    .irr_o(irr_o), .isr_o(isr_o), .imr_o(imr_o), .trig_o(trig_o), .base_o(base_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    mask_we = 0; trig_we = 0; base_we = 0; mode_we = 0;
    ack = 0; eoi_any = 0; eoi_one = 0; eoi_rot = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    irq_in = '0; mask_wd = '0; trig_wd = '0; base_wd = '0; eoi_id = '0;
    mode_aeoi = 0; mode_rot_aeoi = 0; mode_nested = 0;
    idle();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    mask_wd = 8'h5A; mask_we = 1; base_wd = 3'd5; base_we = 1;
    trig_wd = 8'hFF; trig_we = 1; irq_in = 8'h01;
    tick();
    do_reset();
    chk("R1 irr", irr_o, 0); chk("R1 isr", isr_o, 0); chk("R1 imr", imr_o, 0);
    chk("R1 trig", trig_o, 0); chk("R1 base", base_o, 0);
    chk("R1 int_out", int_out, 0); chk("R1 int_req_q", int_req_q, 0);
  endtask

  task automatic t_edge();
    do_reset();
    irq_in[3] = 1; tick();
    chk("R2 edge set", irr_o, 8'h08);
    chk("R5 vec", int_vec, 3); chk("R6 int_out", int_out, 1);
    chk("R12 lag", int_req_q, 0);
    tick();
    chk("R12 follow", int_req_q, 1);
    irq_in[3] = 0; tick();
    chk("R2 fall keeps", irr_o, 8'h08);
  endtask

  task automatic t_level();
    do_reset();
    trig_wd = 8'hFF; trig_we = 1; tick();
    chk("R4 trig mask", trig_o, 8'hF8);
    irq_in[4] = 1; tick();
    chk("R3 level high", irr_o, 8'h10);
    irq_in[4] = 0; tick();
    chk("R3 level low", irr_o, 8'h00);
    irq_in[1] = 1; tick(); irq_in[1] = 0; tick();
    chk("R4 forced edge", irr_o, 8'h02);
  endtask

  task automatic t_priority();
    do_reset();
    irq_in = 8'h28; tick();
    chk("R5 base0", int_vec, 3);
    base_wd = 3'd4; base_we = 1; tick();
    chk("R5 base4 reg", base_o, 4); chk("R5 base4", int_vec, 5);
    base_wd = 3'd6; base_we = 1; tick();
    chk("R5 base6 wrap", int_vec, 3);
    mask_wd = 8'h08; mask_we = 1; tick();
    chk("R6 masked vec", int_vec, 5); chk("R6 masked out", int_out, 1);
    mask_wd = 8'h28; mask_we = 1; tick();
    chk("R6 all masked", int_out, 0);
  endtask

  task automatic t_ack();
    do_reset();
    irq_in[3] = 1; tick();
    ack = 1; tick();
    chk("R7 isr set", isr_o, 8'h08); chk("R7 edge clr", irr_o, 8'h00);
    chk("R6 no pend", int_out, 0);
    irq_in[5] = 1; tick();
    chk("R6 lower blocked", int_out, 0);
    irq_in[3] = 0; tick(); irq_in[3] = 1; tick();
    chk("R6 equal blocked", int_out, 0);
    irq_in[1] = 1; tick();
    chk("R6 higher wins", int_out, 1); chk("R6 higher vec", int_vec, 1);
    ack = 1; tick();
    chk("R7 nest isr", isr_o, 8'h0A);
    do_reset();
    trig_wd = 8'h10; trig_we = 1; tick();
    irq_in[4] = 1; tick();
    ack = 1; tick();
    chk("R7 level isr", isr_o, 8'h10); chk("R7 level keeps irr", irr_o, 8'h10);
    ack = 1; tick();
    chk("R7 idle ack isr", isr_o, 8'h10); chk("R7 idle ack irr", irr_o, 8'h10);
  endtask

  task automatic t_eoi();
    do_reset();
    irq_in[3] = 1; tick(); ack = 1; tick();
    irq_in[1] = 1; tick(); ack = 1; tick();
    chk("R9 setup", isr_o, 8'h0A);
    eoi_any = 1; tick();
    chk("R9 clear best", isr_o, 8'h08); chk("R9 base kept", base_o, 0);
    eoi_any = 1; eoi_rot = 1; tick();
    chk("R9 rot clear", isr_o, 8'h00); chk("R9 rot base", base_o, 4);
    do_reset();
    irq_in[6] = 1; tick(); ack = 1; tick();
    irq_in[0] = 1; tick(); ack = 1; tick();
    eoi_one = 1; eoi_id = 3'd6; eoi_rot = 1; eoi_any = 1; tick();
    chk("R10 specific", isr_o, 8'h01); chk("R10 rot base", base_o, 7);
  endtask

  task automatic t_aeoi();
    do_reset();
    mode_aeoi = 1; mode_rot_aeoi = 1; mode_we = 1; tick();
    irq_in[6] = 1; tick();
    chk("R8 pend", int_out, 1);
    ack = 1; tick();
    chk("R8 isr", isr_o, 0); chk("R8 irr", irr_o, 0); chk("R8 rot", base_o, 7);
    do_reset();
    mode_aeoi = 1; mode_rot_aeoi = 0; mode_we = 1; tick();
    irq_in[2] = 1; tick(); ack = 1; tick();
    chk("R8 no rot isr", isr_o, 0); chk("R8 no rot base", base_o, 0);
  endtask

  task automatic t_nested();
    do_reset();
    irq_in[2] = 1; tick(); ack = 1; tick();
    irq_in[5] = 1; tick();
    chk("R11 off blocked", int_out, 0);
    mode_nested = 1; mode_we = 1; tick();
    chk("R11 on out", int_out, 1); chk("R11 on vec", int_vec, 5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_priority();
    t_ack();
    t_eoi();
    t_aeoi();
    t_nested();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule